// File: doc/BRIEF.md
# External Data Space Access Router

This block sits beside an 8051-class core and steers each external-data move (MOVX) to one of three places. The targets are a 768-byte on-chip expanded RAM, an on-chip data Flash that MOVX may only read, and the off-chip memory bus. The core issues a one-cycle request with an addressing mode. In pointer mode the 16-bit address comes straight from the data pointer. In register mode the 8-bit register value supplies the low byte and a page register supplies the high byte.

Two enable bits in a configuration register decide the routing, together with a fixed upper limit of 0x02FF for the RAM window. Both bits clear at reset, so all MOVX traffic goes off-chip until software enables a target. The configuration register and the page register are reached through a plain special-function-register write/read port.

A write that decodes to the data Flash is discarded. It still completes, and it sets a sticky flag. Accesses to the RAM or the Flash complete one clock after the request. Off-chip accesses hold a request toward the bus until the bus returns ready.

Top module: `movx_router`

## Requirements
- R1: After reset, the configuration register (SFR address 0xBF) and the page register (SFR address 0x85) both read 0x00, the discard flag is low, and a MOVX access goes to the off-chip bus.
- R2: The access address is the 16-bit pointer when mode_ri_i is 0. It is {page register, ri_i} when mode_ri_i is 1.
- R3: With bit 1 (RAM enable) and bit 3 (Flash enable) of the configuration register both 0, every address goes off-chip.
- R4: With only bit 1 set, addresses 0x0000..0x02FF go to the RAM, with the RAM address equal to the low 10 address bits. Higher addresses go off-chip.
- R5: With only bit 3 set, every address goes to the data Flash.
- R6: With both bits set, addresses 0x0000..0x02FF go to the RAM and higher addresses go to the data Flash.
- R7: The configuration register keeps bits 3:0. Bits 7:4 read 0, and bits 0 and 2 are plain storage with no effect on routing. The page register keeps all 8 bits. Any other SFR address reads 0x00.
- R8: A MOVX write that decodes to the Flash issues no Flash request. done_o rises one cycle later, and flash_wr_drop_o goes high and stays high until reset.
- R9: A RAM or Flash access raises done_o exactly one cycle after the request. On a read, rdata_o carries the array's data in that cycle.
- R10: An off-chip access holds ext_req_o, with a stable address, write enable and write data, until ext_ready_i. done_o is high in the cycle where ext_req_o and ext_ready_i are both high, and on a read rdata_o equals ext_rdata_i there.
- R11: A MOVX write to the RAM window reaches the RAM with ram_we_o high and the write data, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR address for write and read |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for sfr_addr_i |
| req_i | input | 1 | MOVX request, one cycle, accepted only while idle |
| mode_ri_i | input | 1 | 1 selects register mode, 0 selects pointer mode |
| dptr_i | input | 16 | Data pointer value |
| ri_i | input | 8 | Register value used in register mode |
| we_i | input | 1 | 1 for a write, 0 for a read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with done_o on a read |
| done_o | output | 1 | Access complete |
| flash_wr_drop_o | output | 1 | Sticky flag set by a discarded Flash write |
| ram_req_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 10 | RAM word address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the strobe |
| flash_req_o | output | 1 | Flash read strobe |
| flash_addr_o | output | 16 | Flash read address |
| flash_rdata_i | input | 8 | Flash read data, one cycle after the strobe |
| ext_req_o | output | 1 | Off-chip request, held until ready |
| ext_we_o | output | 1 | Off-chip write enable |
| ext_addr_o | output | 16 | Off-chip address |
| ext_wdata_o | output | 8 | Off-chip write data |
| ext_rdata_i | input | 8 | Off-chip read data, sampled with ready |
| ext_ready_i | input | 1 | Off-chip access complete |

## Verification
The bench builds the router with its default parameters: a 16-bit address, byte data, the RAM window ending at 0x02FF, and the implemented-bit mask 0x0F. These values make it possible to sweep every enable pairing over both window edges and both address extremes, in both addressing modes. The off-chip model returns ready only on the third cycle of a request, which exercises a held request and a fixed-latency done for internal targets. A read of a value the bench computes for every address shows which target answered.

// File: rtl/movx_router_pkg.sv
package movx_router_pkg;
  typedef enum logic [1:0] {
    TGT_EXT   = 2'd0,
    TGT_RAM   = 2'd1,
    TGT_FLASH = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_BUS   = 2'd2
  } acc_st_e;
endpackage

// File: rtl/movx_cfg_regs.sv
module movx_cfg_regs #(
  parameter int          DW        = 8,
  parameter logic [7:0]  CFG_ADDR  = 8'hBF,
  parameter logic [7:0]  PAGE_ADDR = 8'h85,
  parameter logic [DW-1:0] IMPL_MASK = 8'h0F,
  parameter int          RAM_EN_BIT = 1,
  parameter int          FL_EN_BIT  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    sfr_addr_i,
  input  logic          sfr_we_i,
  input  logic [DW-1:0] sfr_wdata_i,
  output logic [DW-1:0] sfr_rdata_o,
  output logic          ram_en_o,
  output logic          flash_en_o,
  output logic [DW-1:0] page_o
);
  logic [DW-1:0] cfg_q, page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      page_q <= '0;
    end else if (sfr_we_i) begin
      if (sfr_addr_i == CFG_ADDR)  cfg_q  <= sfr_wdata_i & IMPL_MASK;
      if (sfr_addr_i == PAGE_ADDR) page_q <= sfr_wdata_i;
    end
  end

  always_comb begin
    if (sfr_addr_i == CFG_ADDR)       sfr_rdata_o = cfg_q;
    else if (sfr_addr_i == PAGE_ADDR) sfr_rdata_o = page_q;
    else                              sfr_rdata_o = '0;
  end

  assign ram_en_o   = cfg_q[RAM_EN_BIT];
  assign flash_en_o = cfg_q[FL_EN_BIT];
  assign page_o     = page_q;
endmodule

// File: rtl/movx_addr_dec.sv
module movx_addr_dec
  import movx_router_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            DW      = 8,
  parameter logic [AW-1:0] RAM_TOP = 16'h02FF
) (
  input  logic          mode_ri_i,
  input  logic [AW-1:0] dptr_i,
  input  logic [DW-1:0] ri_i,
  input  logic [AW-DW-1:0] page_i,
  input  logic          ram_en_i,
  input  logic          flash_en_i,
  output logic [AW-1:0] addr_o,
  output tgt_e          tgt_o
);
  logic in_window;

  assign addr_o    = mode_ri_i ? {page_i, ri_i} : dptr_i;
  assign in_window = (addr_o <= RAM_TOP);

  // RAM enable claims the low window first, Flash enable claims what is left
  always_comb begin
    if (ram_en_i && in_window) tgt_o = TGT_RAM;
    else if (flash_en_i)       tgt_o = TGT_FLASH;
    else                       tgt_o = TGT_EXT;
  end
endmodule

// File: rtl/movx_access_ctl.sv
module movx_access_ctl
  import movx_router_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int RAM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [AW-1:0]     addr_i,
  input  tgt_e              tgt_i,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o,
  output logic              flash_wr_drop_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              flash_req_o,
  output logic [AW-1:0]     flash_addr_o,
  input  logic [DW-1:0]     flash_rdata_i,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic [DW-1:0]     ext_wdata_o,
  input  logic [DW-1:0]     ext_rdata_i,
  input  logic              ext_ready_i
);
  acc_st_e       st_q;
  tgt_e          tgt_q;
  logic          we_q, drop_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept;

  assign accept = (st_q == ST_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tgt_q   <= TGT_EXT;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q    <= (tgt_i == TGT_EXT) ? ST_BUS : ST_LOCAL;
          tgt_q   <= tgt_i;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          if (tgt_i == TGT_FLASH && we_i) drop_q <= 1'b1;
        end
        ST_LOCAL: st_q <= ST_IDLE;
        ST_BUS:   if (ext_ready_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // arrays see the request in the accept cycle and answer one clock later
  assign ram_req_o    = accept && (tgt_i == TGT_RAM);
  assign ram_we_o     = we_i;
  assign ram_addr_o   = addr_i[RAM_AW-1:0];
  assign ram_wdata_o  = wdata_i;
  assign flash_req_o  = accept && (tgt_i == TGT_FLASH) && !we_i;
  assign flash_addr_o = addr_i;

  assign ext_req_o   = (st_q == ST_BUS);
  assign ext_we_o    = we_q;
  assign ext_addr_o  = addr_q;
  assign ext_wdata_o = wdata_q;

  assign done_o          = (st_q == ST_LOCAL) || ((st_q == ST_BUS) && ext_ready_i);
  assign flash_wr_drop_o = drop_q;

  always_comb begin
    rdata_o = '0;
    if (!we_q) begin
      if (st_q == ST_LOCAL && tgt_q == TGT_RAM)        rdata_o = ram_rdata_i;
      else if (st_q == ST_LOCAL && tgt_q == TGT_FLASH) rdata_o = flash_rdata_i;
      else if (st_q == ST_BUS)                         rdata_o = ext_rdata_i;
    end
  end
endmodule

// File: rtl/movx_router.sv
module movx_router
  import movx_router_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] RAM_TOP   = 16'h02FF,
  parameter logic [7:0]    CFG_ADDR  = 8'hBF,
  parameter logic [7:0]    PAGE_ADDR = 8'h85,
  parameter logic [DW-1:0] IMPL_MASK = 8'h0F,
  parameter int            RAM_EN_BIT = 1,
  parameter int            FL_EN_BIT  = 3,
  localparam int           RAM_AW    = $clog2(int'(RAM_TOP) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_we_i,
  input  logic [DW-1:0]     sfr_wdata_i,
  output logic [DW-1:0]     sfr_rdata_o,
  input  logic              req_i,
  input  logic              mode_ri_i,
  input  logic [AW-1:0]     dptr_i,
  input  logic [DW-1:0]     ri_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o,
  output logic              flash_wr_drop_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              flash_req_o,
  output logic [AW-1:0]     flash_addr_o,
  input  logic [DW-1:0]     flash_rdata_i,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic [DW-1:0]     ext_wdata_o,
  input  logic [DW-1:0]     ext_rdata_i,
  input  logic              ext_ready_i
);
  logic          ram_en, flash_en;
  logic [DW-1:0] page;
  logic [AW-1:0] acc_addr;
  tgt_e          acc_tgt;

  movx_cfg_regs #(
    .DW(DW), .CFG_ADDR(CFG_ADDR), .PAGE_ADDR(PAGE_ADDR), .IMPL_MASK(IMPL_MASK),
    .RAM_EN_BIT(RAM_EN_BIT), .FL_EN_BIT(FL_EN_BIT)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .sfr_addr_i(sfr_addr_i), .sfr_we_i(sfr_we_i),
    .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o), .ram_en_o(ram_en),
    .flash_en_o(flash_en), .page_o(page)
  );

  movx_addr_dec #(.AW(AW), .DW(DW), .RAM_TOP(RAM_TOP)) u_dec (
    .mode_ri_i(mode_ri_i), .dptr_i(dptr_i), .ri_i(ri_i), .page_i(page),
    .ram_en_i(ram_en), .flash_en_i(flash_en), .addr_o(acc_addr), .tgt_o(acc_tgt)
  );

  movx_access_ctl #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .wdata_i(wdata_i),
    .addr_i(acc_addr), .tgt_i(acc_tgt), .rdata_o(rdata_o), .done_o(done_o),
    .flash_wr_drop_o(flash_wr_drop_o), .ram_req_o(ram_req_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .flash_req_o(flash_req_o), .flash_addr_o(flash_addr_o), .flash_rdata_i(flash_rdata_i),
    .ext_req_o(ext_req_o), .ext_we_o(ext_we_o), .ext_addr_o(ext_addr_o),
    .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata_i), .ext_ready_i(ext_ready_i)
  );
endmodule

// File: rtl/movx_router_chk.sv
module movx_router_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RAM_AW = 10,
  parameter logic [AW-1:0] RAM_TOP = 16'h02FF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              flash_wr_drop_o,
  input logic              ram_req_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              flash_req_o,
  input logic              ext_req_o,
  input logic              ext_we_o,
  input logic [AW-1:0]     ext_addr_o,
  input logic [DW-1:0]     ext_wdata_o,
  input logic              ext_ready_i
);
  a_r3_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_req_o, flash_req_o, ext_req_o}));

  a_r4_ram_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_req_o |-> ({{(AW-RAM_AW){1'b0}}, ram_addr_o} <= RAM_TOP));

  a_r9_ram_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_req_o |=> done_o);

  a_r9_flash_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_req_o |=> done_o);

  a_r8_drop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_wr_drop_o |=> flash_wr_drop_o);

  a_r8_drop_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_wr_drop_o) |-> done_o);

  a_r10_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_ready_i) |=>
      (ext_req_o && $stable(ext_addr_o) && $stable(ext_we_o) && $stable(ext_wdata_o)));

  a_r10_done_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && ext_ready_i) |-> done_o);
endmodule

bind movx_router movx_router_chk #(
  .AW(AW), .DW(DW), .RAM_AW(RAM_AW), .RAM_TOP(RAM_TOP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .flash_wr_drop_o(flash_wr_drop_o),
  .ram_req_o(ram_req_o), .ram_addr_o(ram_addr_o), .flash_req_o(flash_req_o),
  .ext_req_o(ext_req_o), .ext_we_o(ext_we_o), .ext_addr_o(ext_addr_o),
  .ext_wdata_o(ext_wdata_o), .ext_ready_i(ext_ready_i)
);

// File: tb/movx_router_bench.sv
module movx_router_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
  logic        sfr_we = 1'b0;
  logic        req = 1'b0, mode_ri = 1'b0, we = 1'b0;
  logic [15:0] dptr = '0;
  logic [7:0]  ri = '0, wdata = '0, rdata;
  logic        done, drop;
  logic        ram_req, ram_we, flash_req, ext_req, ext_we;
  logic [9:0]  ram_addr;
  logic [7:0]  ram_wdata, ram_rdata = '0, flash_rdata = '0, ext_wdata, ext_rdata;
  logic [15:0] flash_addr, ext_addr;
  logic        ext_ready;
  logic [1:0]  ext_cnt;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  movx_router u_movx_router (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(sfr_addr), .sfr_we_i(sfr_we),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .req_i(req), .mode_ri_i(mode_ri),
    .dptr_i(dptr), .ri_i(ri), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .flash_wr_drop_o(drop), .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .flash_req_o(flash_req),
    .flash_addr_o(flash_addr), .flash_rdata_i(flash_rdata), .ext_req_o(ext_req),
    .ext_we_o(ext_we), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata), .ext_ready_i(ext_ready)
  );

  function automatic logic [7:0] ram_init(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hC3;
  endfunction
  function automatic logic [7:0] fl_val(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A ^ 8'h80;
  endfunction
  function automatic logic [7:0] ex_val(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction
  // 0 ext, 1 ram, 2 flash
  function automatic int exp_tgt(input bit ren, input bit fen, input logic [15:0] a);
    if (ren && a <= 16'h02FF) return 1;
    if (fen) return 2;
    return 0;
  endfunction

  // memory models
  logic [7:0] ram_mem [768];
  initial for (int i = 0; i < 768; i++) ram_mem[i] = ram_init(i);
  always @(posedge clk) if (ram_req) begin
    if (ram_we) ram_mem[ram_addr] <= ram_wdata;
    ram_rdata <= ram_mem[ram_addr];
  end
  always @(posedge clk) if (flash_req) flash_rdata <= fl_val(flash_addr);
  assign ext_rdata = ex_val(ext_addr);
  always @(posedge clk) ext_cnt <= ext_req ? ext_cnt + 2'd1 : 2'd0;
  assign ext_ready = ext_req && (ext_cnt == 2'd2);

  // hit monitors
  bit hit_ram, hit_fl, hit_ext, cap_we;
  logic [15:0] cap_addr;
  logic [7:0]  cap_wd;
  always @(posedge clk) begin
    if (ram_req) begin hit_ram <= 1'b1; cap_addr <= {6'd0, ram_addr}; cap_we <= ram_we; cap_wd <= ram_wdata; end
    if (flash_req) begin hit_fl <= 1'b1; cap_addr <= flash_addr; end
    if (ext_req && ext_ready) begin hit_ext <= 1'b1; cap_addr <= ext_addr; cap_we <= ext_we; cap_wd <= ext_wdata; end
  end

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
    end
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk); sfr_we = 1'b0;
  endtask

  task automatic access(input bit mri, input logic [15:0] a, input bit w, input logic [7:0] d,
                        output logic [7:0] rd, output int cyc);
    @(negedge clk);
    hit_ram = 0; hit_fl = 0; hit_ext = 0;
    mode_ri = mri; dptr = mri ? 16'hDEAD : a; ri = mri ? a[7:0] : 8'h3C;
    we = w; wdata = d; req = 1'b1;
    @(negedge clk); req = 1'b0; cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    rd = rdata;
    @(negedge clk);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pts [4] = '{16'h0000, 16'h02FF, 16'h0300, 16'hFFFF};
    logic [7:0] rd;
    int cyc, t, e;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    sfr_addr = 8'hBF; #1 chk("R1", sfr_rdata, 8'h00, "cfg after reset");
    sfr_addr = 8'h85; #1 chk("R1", sfr_rdata, 8'h00, "page after reset");
    chk("R1", drop, 0, "drop flag after reset");
    access(0, 16'h0010, 0, 0, rd, cyc);
    chk("R1", {hit_ram, hit_fl, hit_ext}, 3'b001, "reset routing off-chip");

    // R7 register storage
    sfr_wr(8'hBF, 8'hFF); sfr_addr = 8'hBF; #1 chk("R7", sfr_rdata, 8'h0F, "cfg masked");
    sfr_wr(8'h85, 8'hA5); sfr_addr = 8'h85; #1 chk("R7", sfr_rdata, 8'hA5, "page store");
    sfr_addr = 8'h80; #1 chk("R7", sfr_rdata, 8'h00, "unmapped SFR");
    sfr_wr(8'hBF, 8'hF5); sfr_addr = 8'hBF; #1 chk("R7", sfr_rdata, 8'h05, "plain bits");
    access(0, 16'h0000, 0, 0, rd, cyc);
    chk("R7", {hit_ram, hit_fl, hit_ext}, 3'b001, "bits 0/2 no routing effect");

    // R2-R6, R9, R10 sweep
    for (int en = 0; en < 4; en++) begin
      sfr_wr(8'hBF, {4'd0, en[1], 1'b0, en[0], 1'b0});
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 4; p++) begin
          if (m == 1) sfr_wr(8'h85, pts[p][15:8]);
          access(m[0], pts[p], 0, 0, rd, cyc);
          t = exp_tgt(en[0], en[1], pts[p]);
          e = (t == 1) ? 3'b100 : (t == 2) ? 3'b010 : 3'b001;
          chk(en == 0 ? "R3" : en == 1 ? "R4" : en == 2 ? "R5" : "R6",
              {hit_ram, hit_fl, hit_ext}, e, "target");
          chk("R2", cap_addr, (t == 1) ? {6'd0, pts[p][9:0]} : pts[p], "access address");
          chk(t == 0 ? "R10" : "R9", rd,
              (t == 1) ? ram_init(int'(pts[p][9:0])) : (t == 2) ? fl_val(pts[p]) : ex_val(pts[p]),
              "read data");
          chk(t == 0 ? "R10" : "R9", cyc, (t == 0) ? 3 : 1, "done latency");
        end
      end
    end

    // R11 RAM write then read
    sfr_wr(8'hBF, 8'h02);
    access(0, 16'h02FF, 1, 8'h9E, rd, cyc);
    chk("R11", {hit_ram, cap_we, cap_wd}, {1'b1, 1'b1, 8'h9E}, "ram write strobe");
    sfr_wr(8'h85, 8'h02);
    access(1, 16'h02FF, 0, 0, rd, cyc);
    chk("R11", rd, 8'h9E, "ram readback");

    // R10 off-chip write
    access(0, 16'h1234, 1, 8'h77, rd, cyc);
    chk("R10", {hit_ext, cap_we, cap_wd, cap_addr}, {1'b1, 1'b1, 8'h77, 16'h1234}, "ext write");
    chk("R10", cyc, 3, "ext write latency");

    // R8 discarded Flash write
    sfr_wr(8'hBF, 8'h08);
    chk("R8", drop, 0, "flag clear before");
    access(0, 16'h4000, 1, 8'h55, rd, cyc);
    chk("R8", {hit_ram, hit_fl, hit_ext}, 3'b000, "no request issued");
    chk("R8", cyc, 1, "drop completes");
    chk("R8", drop, 1, "flag set");
    access(0, 16'h4000, 0, 0, rd, cyc);
    chk("R8", rd, fl_val(16'h4000), "flash unchanged read");
    chk("R8", drop, 1, "flag sticky");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule